// File: doc/BRIEF.md
# Row Address Clock Sequencer

This block walks a row pointer through a storage array of rows and produces the row address clock that marks each row's progress. In normal play or record operation the row timer advances once per sample tick. In cueing operation it advances once per master-clock cycle, so a row passes many times faster. The clock output is an open-drain pull-down enable. It is released (line high) for most of a row and driven low over the closing part of the row. The pointer is the value a serial control port reads back.

A controller starts an operation with a one-cycle `start` pulse and chooses the mode, the direction and whether to take a new address. It ends the operation with `stop`, or lets the block end by itself. At each row boundary the live `ignore_addr` input decides whether the row repeats or the pointer advances. Running off the last row raises an overflow flag. In cueing mode an end-of-message marker in the current row stops the scan, with the pointer already on the following row. Each self-ended operation gives one `done` pulse.

Top module: `rac_row_sequencer`

## Requirements
- R1: After reset `row_ptr` is 0, `rac_drive_low` is 0, `ovf` is 0 and `done` is 0.
- R2: A `start` pulse while idle begins an operation in the next cycle. With `ignore_addr`=0 the pointer takes `load_addr`; with `ignore_addr`=1 the pointer keeps its current value.
- R3: In normal mode a row lasts ROW_CELLS cycles in which `sample_tick` is 1. Cycles with `sample_tick`=0 do not advance the row. `rac_drive_low` is 1 exactly while the row position is within the last ROW_LOW ticks.
- R4: In cueing mode (`cue_mode`=1 at start) a row lasts CUE_LEN clock cycles whatever `sample_tick` does. `rac_drive_low` is 1 in the last CUE_LOW cycles.
- R5: For a record operation (`rec_mode`=1 at start, normal mode) the first row lasts ROW_CELLS+ROW_LOW ticks. The extra ticks lengthen the released phase, the low phase stays ROW_LOW ticks, and later rows have the normal length. Playback rows are never lengthened.
- R6: At the end of a normal-mode row, `ignore_addr`=0 repeats the same row and `ignore_addr`=1 advances `row_ptr` by one.
- R7: An advance past row ROWS-1 sets `ovf`, ends the operation, leaves `row_ptr` at ROWS-1, releases RAC and gives a one-cycle `done`. `ovf` holds until the next accepted start, which clears it.
- R8: In cueing mode rows always advance. If `eom_mark` is 1 at a row end, the operation ends with `row_ptr` on the next row, `done` pulses once and `ovf` stays 0. If that row is the last row, R7 applies.
- R9: `stop` during an operation makes the block idle in the next cycle. The pointer is held, RAC is released and no `done` is produced.
- R10: A `start` pulse during an operation is ignored: the pointer, the row timing and the mode do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_tick | input | 1 | Sample-rate enable for normal-mode row timing |
| start | input | 1 | Begin an operation (ignored while busy) |
| stop | input | 1 | End the current operation |
| cue_mode | input | 1 | 1 = fast cueing scan, sampled at start |
| rec_mode | input | 1 | 1 = record, 0 = playback, sampled at start |
| ignore_addr | input | 1 | 0 = load address at start and repeat rows; 1 = keep pointer and advance |
| load_addr | input | $clog2(ROWS) | Row address taken at start when ignore_addr is 0 |
| eom_mark | input | 1 | End-of-message marker present in the current row (cueing) |
| rac_drive_low | output | 1 | Open-drain enable: 1 pulls the row address clock low |
| row_ptr | output | $clog2(ROWS) | Current row pointer |
| ovf | output | 1 | End of memory reached |
| done | output | 1 | One-cycle pulse when an operation ends by itself |

## Verification
The bench targets row boundaries. If the repeat/advance choice were taken from the value latched at start rather than the live input, the pointer would stay on row 2 or leave it one row early. With ticks arriving every other cycle, a timer that counts clocks in normal mode would put the low phase and the row change far too early. The stretched first record row and the overflow on the last row are checked down to the exact cycle. So are a cueing scan that must not repeat rows and an end-of-message stop that must leave the pointer on the following row. A restart during a running row is also checked, because re-arming the timer there would shift every later low phase.

// File: rtl/rac_pkg.sv
package rac_pkg;

  // Operation attributes captured when a start is accepted.
  typedef struct packed {
    logic cue;   // fast scan at master-clock rate
    logic rec;   // record direction (stretches the first row)
  } op_cfg_t;

endpackage

// File: rtl/rac_row_timer.sv
module rac_row_timer #(
  parameter int ROW_LEN = 1600,
  parameter int ROW_LOW = 200,
  parameter int CUE_LEN = 64,
  parameter int CUE_LOW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic cue,
  input  logic stretch,
  input  logic sample_tick,
  output logic row_end,
  output logic low_phase
);

  localparam int NORM_MAX = ROW_LEN + ROW_LOW;
  localparam int MAX_LEN  = (NORM_MAX > CUE_LEN) ? NORM_MAX : CUE_LEN;
  localparam int CNT_W    = $clog2(MAX_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit, low_from;
  logic             step;

  always_comb begin
    if (cue) begin
      limit    = CNT_W'(CUE_LEN - 1);
      low_from = CNT_W'(CUE_LEN - CUE_LOW);
    end else if (stretch) begin
      limit    = CNT_W'(NORM_MAX - 1);
      low_from = CNT_W'(ROW_LEN);
    end else begin
      limit    = CNT_W'(ROW_LEN - 1);
      low_from = CNT_W'(ROW_LEN - ROW_LOW);
    end
  end

  assign step      = run & (cue | sample_tick);
  assign row_end   = step & (cnt_q == limit);
  assign low_phase = run & (cnt_q >= low_from);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (row_end) cnt_d = '0;
    else if (step)    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // A row can only close while the clock is in its low phase.
  AST_END_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |-> low_phase) else $error("row end outside low phase"); // R3

endmodule

// File: rtl/rac_row_ptr.sv
module rac_row_ptr #(
  parameter int ROWS  = 600,
  parameter int PTR_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr,
  output logic             at_last
);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)     ptr_d = load_val;
    else if (adv) ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr     = ptr_q;
  assign at_last = (ptr_q == PTR_W'(ROWS - 1));

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> ({1'b0, ptr_q} < (PTR_W+1)'(ROWS))) else $error("pointer past array"); // R6

endmodule

// File: rtl/rac_row_sequencer.sv
module rac_row_sequencer
  import rac_pkg::*;
#(
  parameter int ROWS      = 600,
  parameter int ROW_CELLS = 1600,
  parameter int ROW_LOW   = 200,
  parameter int CUE_LEN   = 64,
  parameter int CUE_LOW   = 8,
  localparam int PTR_W    = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             start,
  input  logic             stop,
  input  logic             cue_mode,
  input  logic             rec_mode,
  input  logic             ignore_addr,
  input  logic [PTR_W-1:0] load_addr,
  input  logic             eom_mark,
  output logic             rac_drive_low,
  output logic [PTR_W-1:0] row_ptr,
  output logic             ovf,
  output logic             done
);

  logic    busy_q, busy_d;
  logic    first_q, first_d;
  logic    ovf_q, ovf_d;
  logic    done_q, done_d;
  op_cfg_t cfg_q, cfg_d;

  logic launch, halt, row_end, low_phase, at_last;
  logic stretch, adv_want, adv, hit_end, eom_stop;

  // Control decode
  assign launch   = start & ~busy_q;
  assign halt     = stop & busy_q;
  assign stretch  = cfg_q.rec & ~cfg_q.cue & first_q;
  assign adv_want = row_end & ~halt & (cfg_q.cue | ignore_addr);
  assign adv      = adv_want & ~at_last;
  assign hit_end  = adv_want & at_last;
  assign eom_stop = row_end & ~halt & cfg_q.cue & eom_mark & ~at_last;

  rac_row_timer #(
    .ROW_LEN (ROW_CELLS),
    .ROW_LOW (ROW_LOW),
    .CUE_LEN (CUE_LEN),
    .CUE_LOW (CUE_LOW)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (launch),
    .run         (busy_q),
    .cue         (cfg_q.cue),
    .stretch     (stretch),
    .sample_tick (sample_tick),
    .row_end     (row_end),
    .low_phase   (low_phase)
  );

  rac_row_ptr #(
    .ROWS  (ROWS),
    .PTR_W (PTR_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch & ~ignore_addr),
    .load_val (load_addr),
    .adv      (adv),
    .ptr      (row_ptr),
    .at_last  (at_last)
  );

  // Next state
  always_comb begin
    busy_d  = busy_q;
    first_d = first_q;
    ovf_d   = ovf_q;
    cfg_d   = cfg_q;
    done_d  = hit_end | eom_stop;
    if (launch) begin
      busy_d    = 1'b1;
      first_d   = 1'b1;
      ovf_d     = 1'b0;
      cfg_d.cue = cue_mode;
      cfg_d.rec = rec_mode;
    end else begin
      if (row_end)                     first_d = 1'b0;
      if (hit_end)                     ovf_d   = 1'b1;
      if (halt | hit_end | eom_stop)   busy_d  = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      first_q <= first_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
      cfg_q   <= cfg_d;
    end
  end

  assign rac_drive_low = low_phase;
  assign ovf           = ovf_q;
  assign done          = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R7
  AST_OVF_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !busy_q) else $error("running with overflow set"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(row_ptr)) else $error("idle pointer moved"); // R9

endmodule

// File: tb/sim_rac_row_sequencer.sv
module sim_rac_row_sequencer;

  localparam int ROWS = 6;
  localparam int PW   = $clog2(ROWS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sample_tick = 1'b1;
  logic          tick_half;
  logic          start, stop, cue_mode, rec_mode, ignore_addr, eom_mark;
  logic [PW-1:0] load_addr;
  logic          rac_drive_low, ovf, done;
  logic [PW-1:0] row_ptr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [PW-1:0] ptr;
    logic          low;
    logic          ovf;
    logic          done;
    string         tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  rac_row_sequencer #(
    .ROWS (ROWS), .ROW_CELLS (16), .ROW_LOW (2), .CUE_LEN (8), .CUE_LOW (1)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .sample_tick (sample_tick), .start (start),
    .stop (stop), .cue_mode (cue_mode), .rec_mode (rec_mode),
    .ignore_addr (ignore_addr), .load_addr (load_addr), .eom_mark (eom_mark),
    .rac_drive_low (rac_drive_low), .row_ptr (row_ptr), .ovf (ovf), .done (done)
  );

  // Tick source: constant 1, or toggling every cycle.
  always @(negedge clk) begin
    if (tick_half) sample_tick <= ~sample_tick;
    else           sample_tick <= 1'b1;
  end

  // Monitor: one expected item per cycle, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (row_ptr !== e.ptr || rac_drive_low !== e.low || ovf !== e.ovf || done !== e.done) begin
        errors++;
        $display("FAIL %s: got ptr=%0d low=%0b ovf=%0b done=%0b, expected ptr=%0d low=%0b ovf=%0b done=%0b",
                 e.tag, row_ptr, rac_drive_low, ovf, done, e.ptr, e.low, e.ovf, e.done);
      end
    end
  end

  task automatic put(input int p, input bit l, input bit o, input bit d, input string t);
    exp_t e;
    e.ptr = PW'(p); e.low = l; e.ovf = o; e.done = d; e.tag = t;
    q.push_back(e);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    cyc(1);
  endtask

  initial begin
    rst_n = 1'b0; tick_half = 1'b0;
    start = 0; stop = 0; cue_mode = 0; rec_mode = 0; ignore_addr = 0; eom_mark = 0;
    load_addr = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    put(0, 0, 0, 0, "R1");
    drain();

    // Playback, row 2 repeats, then advances once ignore_addr goes high, then stop.
    put(0, 0, 0, 0, "R1");
    for (int k = 0; k <= 40; k++)
      put((k < 32) ? 2 : 3, (k % 16) >= 14, 0, 0, (k < 32) ? "R2/R6" : "R3/R6");
    for (int k = 41; k <= 43; k++) put(3, 0, 0, 0, "R9");
    load_addr = 2; ignore_addr = 0; cue_mode = 0; rec_mode = 0; start = 1;
    cyc(1); start = 0;
    cyc(20); ignore_addr = 1;
    cyc(20); stop = 1;
    cyc(1); stop = 0;
    drain();

    // Half-rate ticks, keep pointer, restart attempt mid-row is ignored.
    tick_half = 1'b1;
    cyc(3);
    while (sample_tick !== 1'b1) cyc(1);
    put(3, 0, 0, 0, "R9");
    for (int k = 0; k <= 40; k++) begin
      int c;
      c = (k + 1) / 2;
      put(3 + c / 16, (c % 16) >= 14, 0, 0, (k > 5) ? "R3/R10" : "R2/R3");
    end
    for (int k = 41; k <= 43; k++) put(4, 0, 0, 0, "R9");
    load_addr = 0; ignore_addr = 1; start = 1;
    cyc(1); start = 0;
    cyc(5); start = 1; rec_mode = 1; ignore_addr = 1;
    cyc(1); start = 0; rec_mode = 0;
    cyc(34); stop = 1;
    cyc(1); stop = 0;
    drain();

    // Record: stretched first row, then overflow on the last row.
    tick_half = 1'b0;
    cyc(2);
    put(4, 0, 0, 0, "R9");
    for (int k = 0; k <= 17; k++) put(4, k >= 16, 0, 0, "R5");
    for (int k = 18; k <= 33; k++) put(5, (k - 18) >= 14, 0, 0, "R5/R6");
    put(5, 0, 1, 1, "R7");
    put(5, 0, 1, 0, "R7");
    put(5, 0, 1, 0, "R7");
    load_addr = 4; ignore_addr = 0; rec_mode = 1; start = 1;
    cyc(1); start = 0; rec_mode = 0;
    cyc(2); ignore_addr = 1;
    drain();

    // Cueing scan with ignore_addr low, end-of-message stop in row 3.
    tick_half = 1'b1;
    put(5, 0, 1, 0, "R7");
    for (int k = 0; k <= 23; k++) put(1 + k / 8, (k % 8) == 7, 0, 0, (k == 0) ? "R7" : "R4/R8");
    put(4, 0, 0, 1, "R8");
    put(4, 0, 0, 0, "R8");
    load_addr = 1; ignore_addr = 0; cue_mode = 1; start = 1;
    cyc(1); start = 0;
    cyc(17); eom_mark = 1;
    drain();
    eom_mark = 0;
    cyc(1);

    // Cueing off the end of memory.
    put(4, 0, 0, 0, "R8");
    for (int k = 0; k <= 15; k++) put(4 + k / 8, (k % 8) == 7, 0, 0, "R4");
    put(5, 0, 1, 1, "R8");
    put(5, 0, 1, 0, "R7");
    load_addr = 4; ignore_addr = 0; cue_mode = 1; start = 1;
    cyc(1); start = 0;
    drain();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule